// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the effective array address of a synchronous SRAM that needs no turnaround cycles. On every clock that carries a valid access, a load/advance control decides the address. With the control low, the block takes the address presented on the external bus as the start of a new burst. With the control high, it steps an internal two-bit beat counter and builds the address from the stored start and the new beat.

A static order input chooses how the low two address bits move through a burst: linear (counting up modulo four) or interleaved (start bits XOR beat). The bits above the low two come from the load cycle and do not change while the burst runs. After four beats the counter returns to the start. The result is registered, so the address selected by the control sampled at a clock edge appears at the output right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), addr_o is zero and the beat count is zero.
- R2: A clock edge with valid_i high and adv_i low loads addr_i: addr_o equals the sampled addr_i right after that edge, and the beat count becomes 0.
- R3: With order_i = 0 (linear), the k-th advance after a load gives addr_o[1:0] = (start[1:0] + k) mod 4.
- R4: With order_i = 1 (interleaved), the k-th advance after a load gives addr_o[1:0] = start[1:0] XOR (k mod 4).
- R5: The fourth advance after a load returns the output to the loaded start address, and later advances repeat the same four-address cycle.
- R6: During an advance, addr_o bits above bit 1 keep their load-cycle value, and addr_i has no effect on the output.
- R7: A clock edge with valid_i low leaves addr_o unchanged and does not step the beat count, whatever adv_i and addr_i hold.
- R8: Advances with no load since reset use address zero as the start.
- R9: A load while a burst is in progress, including at the beat where the counter would wrap, sets a new start and restarts the beat count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Access present this cycle |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new start |
| order_i | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External address, used on load only |
| addr_o | output | ADDR_W | Registered effective address |

## Verification
Loading and wrapping can fall in the same cycle: a load arriving at the beat where the counter would have returned to zero. The bench runs three advances after a load and then presents a new start address at the wrap point. It judges the result by requiring the new address at once and a count that restarts from it, not a continuation of the old burst. Reloading after a single advance exercises the same priority of load over stepping in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic {
    CTL_LOAD    = 1'b0,
    CTL_ADVANCE = 1'b1
  } burst_ctl_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_nxt_o
);

  logic [BEAT_W-1:0] beat_q;

  assign beat_nxt_o = beat_q + {{(BEAT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_nxt_o;
    end
  end

endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] lin_w;
  logic [BEAT_W-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load_w;
  logic              step_w;
  logic [BEAT_W-1:0] beat_nxt_w;
  logic [BEAT_W-1:0] start_lo_q;
  logic [BEAT_W-1:0] low_nxt_w;
  logic [ADDR_W-1:0] addr_q;
  burst_order_e      order_w;

  assign order_w = burst_order_e'(order_i);
  assign load_w  = valid_i && (burst_ctl_e'(adv_i) == CTL_LOAD);
  assign step_w  = valid_i && (burst_ctl_e'(adv_i) == CTL_ADVANCE);

  bseq_beat_ctr #(
    .BEAT_W (BEAT_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (load_w),
    .step_i     (step_w),
    .beat_nxt_o (beat_nxt_w)
  );

  bseq_low_map #(
    .BEAT_W (BEAT_W)
  ) u_map (
    .order_i (order_w),
    .start_i (start_lo_q),
    .beat_i  (beat_nxt_w),
    .low_o   (low_nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_lo_q <= '0;
      addr_q     <= '0;
    end else if (load_w) begin
      start_lo_q <= addr_i[BEAT_W-1:0];
      addr_q     <= addr_i;
    end else if (step_w) begin
      addr_q     <= {addr_q[ADDR_W-1 -: HI_W], low_nxt_w};
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic              adv_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);

  logic all_lin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      all_lin_q <= 1'b1;
    end else if (valid_i && !adv_i) begin
      all_lin_q <= 1'b1;
    end else if (valid_i && adv_i && order_i) begin
      all_lin_q <= 1'b0;
    end
  end

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !adv_i) |=> (addr_o == $past(addr_i)));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && adv_i && !order_i && all_lin_q) |=>
      (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  assert_upper_held_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && adv_i) |=>
      (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!valid_i) |=> $stable(addr_o));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .adv_i   (adv_i),
  .order_i (order_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [AW-1:0] m_start = '0;
  int            m_k = 0;
  logic          done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .adv_i(adv_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] model_addr(logic ord);
    logic [1:0] lo;
    logic [1:0] kk;
    kk = 2'(m_k % 4);
    lo = ord ? (m_start[1:0] ^ kk) : 2'(m_start[1:0] + kk);
    return {m_start[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp);
    n_vec++;
    if (addr_o[1:0] !== exp[1:0]) begin
      n_bad++;
      $display("FAIL %s low bits: got %0h expected %0h", tag, addr_o[1:0], exp[1:0]);
    end
    n_vec++;
    if (addr_o[AW-1:2] !== exp[AW-1:2]) begin
      n_bad++;
      $display("FAIL R6/%s upper bits: got %0h expected %0h", tag, addr_o[AW-1:2], exp[AW-1:2]);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register)
  task automatic cyc(logic v, logic a, logic [AW-1:0] ad, string tag);
    valid_i = v; adv_i = a; addr_i = ad;
    @(negedge clk);
    if (v && !a) begin
      m_start = ad; m_k = 0;
    end else if (v && a) begin
      m_k = (m_k + 1) % 4;
    end
    check(tag, model_addr(order_i));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_vec++; n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
          $finish;
        end
      end
    join_none

    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset", '0);

    // R8: advance with no prior load starts at zero; R7 idle interleaved
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b1, 20'hABCDE, "R8 no-load advance");
      cyc(1'b0, 1'b1, 20'h12345, "R7 idle");
    end

    // Sweep order, start low bits, upper patterns
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        for (int h = 0; h < 3; h++) begin
          logic [AW-3:0] hi;
          hi = (h == 0) ? '0 : (h == 1) ? 18'h2A5F3 : '1;
          order_i = ord[0];
          cyc(1'b1, 1'b0, {hi, 2'(s)}, "R2 load");
          for (int b = 0; b < 7; b++) begin
            cyc(1'b1, 1'b1, ~{hi, 2'(s)}, (m_k == 3) ? "R5 wrap" : (ord != 0) ? "R4 interleave" : "R3 linear");
            if (b == 2) begin
              cyc(1'b0, 1'b0, 20'h5A5A5, "R7 idle load-ignored");
              cyc(1'b0, 1'b1, 20'hFFFFF, "R7 idle adv-ignored");
            end
          end
        end
      end
    end

    // R9: reload mid-burst and at the wrap point
    for (int ord = 0; ord < 2; ord++) begin
      order_i = ord[0];
      cyc(1'b1, 1'b0, 20'h00011, "R2 load");
      cyc(1'b1, 1'b1, 20'h0, "R3/R4 step");
      cyc(1'b1, 1'b0, 20'h7F002, "R9 mid-burst reload");
      for (int b = 0; b < 3; b++) cyc(1'b1, 1'b1, 20'h0, "R9 after reload");
      cyc(1'b1, 1'b0, 20'h30003, "R9 reload at wrap");
      for (int b = 0; b < 5; b++) cyc(1'b1, 1'b1, 20'h0, "R9 after wrap reload");
    end

    // R1 again: reset in mid-burst
    valid_i = 1'b1; adv_i = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; valid_i = 1'b0;
    m_start = '0; m_k = 0;
    check("R1 reset mid-burst", '0);
    cyc(1'b1, 1'b1, 20'hFFFFF, "R8 advance after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule